// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose write data trails its write command by two clock cycles. Read data also appears two cycles after its command. Because the two latencies match, the data bus never needs an idle cycle when a read follows a write or a write follows a read.

Every command (read, write or no operation) is captured on a rising clock edge while the clock enable is high. A burst-advance input lets a controller issue up to four accesses from one start address. In a burst, the block generates each next address itself, in linear or interleaved order, and repeats the operation type of the previous cycle.

Per-byte write enables allow partial writes. Three chip-select inputs must all be in their active state for a new command. An asynchronous output enable gates the output drivers. Read data stays coherent with writes that are still waiting for their data, and the merge is done byte lane by byte lane.

Top module: `ntd_sram`

## Requirements
- R1: A new command is taken on a rising edge with `clk_en` high and `adv` low. When the device is selected, `rd_wr_n`=0 requests a write and `rd_wr_n`=1 requests a read. The command's `addr` and `be_n` are captured on the same edge.
- R2: The write data for a command captured on enabled edge n is sampled from `dq_in` on enabled edge n+2 and stored in the word at the captured address.
- R3: A read captured on enabled edge n drives the word on `dq_out`, with `dq_oe` high, in the cycle that follows enabled edge n+2. It stops driving after the next enabled edge unless that edge completes another read.
- R4: Reads and writes can be issued on every enabled edge in any order, with no idle cycle. A read returns every write captured before it, including a write whose data arrives on the same edge as the read's array access.
- R5: `be_n[i]`=0 enables byte lane i, which is data bits [i*BYTE_W +: BYTE_W]. Only enabled lanes are written. With `be_n` all zero, the full word is written.
- R6: With `adv`=1, the inputs `addr`, the chip selects and `rd_wr_n` are ignored. The operation type of the previous enabled cycle is repeated, including no operation after a deselect. `be_n` is still sampled on each burst write.
- R7: In a burst, the k-th `adv` cycle after a start address s (k counted modulo 4) accesses the word with the upper address bits of s. The two low bits are (s+k) mod 4 when `burst_ilv`=0 and s XOR k when `burst_ilv`=1.
- R8: With `clk_en`=0, the edge changes nothing. The command pipeline, the burst position, the array and the output register all hold, and no write data is sampled.
- R9: The device is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A non-burst cycle with any select inactive issues no operation. Commands already issued still complete, and `dq_oe` falls once no read is completing.
- R10: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock edge. `oe_n` has no effect on writes or on the pipeline.
- R11: A synchronous reset (`rst`=1 on an edge) discards pending commands and burst state. `dq_oe` stays low until a read issued after reset completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable; low stalls the whole block |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| be_n | input | NUM_BYTES | Byte-lane write enables, active low |
| adv | input | 1 | Burst advance |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | NUM_BYTES*BYTE_W | Write data from the bus |
| dq_out | output | NUM_BYTES*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus driver enable for `dq_out` |

## Verification
The bench builds the block with ADDR_W=5 and BYTE_W=9, which gives a 32-word array of 36-bit words. At that depth, burst writes can fill the whole array before any read, so every read has a known expected value. Random addresses in that small space often land on a word whose write is still in flight, which exercises the same-edge lane merge many times. The 9-bit lanes also check that lane slicing does not assume 8-bit bytes.

// File: rtl/ntd_pkg.sv
package ntd_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits of a burst step: linear adds, interleaved XORs.
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/ntd_cmd_gen.sv
module ntd_cmd_gen
  import ntd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sel,
  input  logic              rd_wr_n,
  input  logic              adv,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nxt;
  op_e               last_q;

  always_comb begin
    step_nxt = adv ? (step_q + 2'd1) : 2'd0;
    if (adv) begin
      op_o   = last_q;
      addr_o = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], step_nxt, burst_ilv)};
    end else begin
      op_o   = sel ? (rd_wr_n ? OP_RD : OP_WR) : OP_NONE;
      addr_o = addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= 2'd0;
      last_q <= OP_NONE;
    end else if (clk_en) begin
      last_q <= op_o;
      step_q <= step_nxt;
      if (!adv) base_q <= addr;
    end
  end

endmodule

// File: rtl/ntd_pipe.sv
module ntd_pipe
  import ntd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_en,
  input  op_e                  op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BYTES-1:0] be_n_i,
  output op_e                  s1_op,
  output logic [ADDR_W-1:0]    s1_addr,
  output op_e                  s2_op,
  output logic [ADDR_W-1:0]    s2_addr,
  output logic [NUM_BYTES-1:0] s2_be_n
);

  logic [NUM_BYTES-1:0] s1_be_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      s1_be_n <= '1;
      s2_op   <= OP_NONE;
      s2_addr <= '0;
      s2_be_n <= '1;
    end else if (clk_en) begin
      s1_op   <= op_i;
      s1_addr <= addr_i;
      s1_be_n <= be_n_i;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be_n <= s1_be_n;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op)
                 && $stable(s2_addr) && $stable(s2_be_n)));

endmodule

// File: rtl/ntd_mem.sv
module ntd_mem #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [NUM_BYTES-1:0]          wr_mask,
  input  logic [NUM_BYTES*BYTE_W-1:0]   wr_data,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [NUM_BYTES*BYTE_W-1:0]   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  // One simple dual-port array per byte lane, read-first, registered read.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] ram [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) ram[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
      if (rd_en) rd_q <= ram[rd_addr];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = rd_q;
  end

endmodule

// File: rtl/ntd_out_stage.sv
module ntd_out_stage #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clk_en,
  input  logic                        cap_en,
  input  logic [NUM_BYTES-1:0]        byp_mask,
  input  logic [NUM_BYTES*BYTE_W-1:0] byp_data,
  input  logic [NUM_BYTES*BYTE_W-1:0] rd_data,
  input  logic                        s2_rd,
  output logic [NUM_BYTES*BYTE_W-1:0] dout,
  output logic                        dvld
);

  localparam int W = NUM_BYTES * BYTE_W;

  logic [NUM_BYTES-1:0] mask_q;
  logic [W-1:0]         data_q;
  logic [W-1:0]         merged;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = mask_q[g] ? data_q[g*BYTE_W +: BYTE_W]
                                                  : rd_data[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      data_q <= '0;
      dout   <= '0;
      dvld   <= 1'b0;
    end else if (clk_en) begin
      dvld <= s2_rd;
      if (cap_en) begin
        mask_q <= byp_mask;
        data_q <= byp_data;
      end
      if (s2_rd) dout <= merged;
    end
  end

endmodule

// File: rtl/ntd_sram.sv
module ntd_sram
  import ntd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clk_en,
  input  logic                        cs0_n,
  input  logic                        cs1,
  input  logic                        cs2_n,
  input  logic                        rd_wr_n,
  input  logic [NUM_BYTES-1:0]        be_n,
  input  logic                        adv,
  input  logic                        burst_ilv,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        oe_n,
  input  logic [NUM_BYTES*BYTE_W-1:0] dq_in,
  output logic [NUM_BYTES*BYTE_W-1:0] dq_out,
  output logic                        dq_oe
);

  localparam int W = NUM_BYTES * BYTE_W;

  logic                 sel;
  op_e                  cmd_op;
  logic [ADDR_W-1:0]    cmd_addr;
  op_e                  s1_op;
  logic [ADDR_W-1:0]    s1_addr;
  op_e                  s2_op;
  logic [ADDR_W-1:0]    s2_addr;
  logic [NUM_BYTES-1:0] s2_be_n;
  logic                 wr_go;
  logic                 rd_go;
  logic                 hit;
  logic [NUM_BYTES-1:0] byp_mask;
  logic [W-1:0]         rd_data;
  logic                 dvld;

  assign sel = !cs0_n && cs1 && !cs2_n;

  ntd_cmd_gen #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel(sel), .rd_wr_n(rd_wr_n),
    .adv(adv), .burst_ilv(burst_ilv), .addr(addr),
    .op_o(cmd_op), .addr_o(cmd_addr)
  );

  ntd_pipe #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_pipe (
    .clk(clk), .rst(rst), .clk_en(clk_en),
    .op_i(cmd_op), .addr_i(cmd_addr), .be_n_i(be_n),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be_n(s2_be_n)
  );

  // Write commits from stage 2 with bus data; read fetches from stage 1.
  assign wr_go    = clk_en && (s2_op == OP_WR);
  assign rd_go    = clk_en && (s1_op == OP_RD);
  assign hit      = (s2_op == OP_WR) && (s1_addr == s2_addr);
  assign byp_mask = hit ? ~s2_be_n : '0;

  ntd_mem #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .wr_en(wr_go), .wr_addr(s2_addr), .wr_mask(~s2_be_n),
    .wr_data(dq_in), .rd_en(rd_go), .rd_addr(s1_addr), .rd_data(rd_data)
  );

  ntd_out_stage #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cap_en(rd_go),
    .byp_mask(byp_mask), .byp_data(dq_in), .rd_data(rd_data),
    .s2_rd(s2_op == OP_RD), .dout(dq_out), .dvld(dvld)
  );

  assign dq_oe = dvld && !oe_n;

  // R3
  out_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_op == OP_RD) |=> dvld);

  // R9
  hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_op != OP_RD) |=> !dq_oe);

  // R6
  burst_type_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv) |=> (s1_op == $past(s1_op)));

  // R7
  burst_group_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv && s1_op != OP_NONE) |=>
      ((s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])) && (s1_addr != $past(s1_addr))));

endmodule

// File: tb/sim_ntd_sram.sv
module sim_ntd_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 5;
  localparam int NB    = 4;
  localparam int BW    = 9;
  localparam int W     = NB * BW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] SEL = 3'b010; // {cs2_n, cs1, cs0_n}

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
  logic          rd_wr_n = 1'b1;
  logic [NB-1:0] be_n = '1;
  logic          adv = 1'b0;
  logic          burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [W-1:0]  dq_in = '0;
  logic [W-1:0]  dq_out;
  logic          dq_oe;

  int n_checks = 0;
  int n_errors = 0;
  string tag = "R11";

  ntd_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .rd_wr_n(rd_wr_n), .be_n(be_n), .adv(adv), .burst_ilv(burst_ilv), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: queue of issued commands, array of words.
  logic [W-1:0]  ref_mem [DEPTH];
  int            q_op [$];   // 0 none, 1 read, 2 write
  int            q_addr [$];
  logic [NB-1:0] q_be [$];
  int            last_ty = 0;
  int            b_start = 0;
  int            b_k = 0;
  logic          exp_vld = 1'b0;
  logic [W-1:0]  exp_data = '0;

  always @(posedge clk) begin : model
    int ty;
    int a;
    if (rst) begin
      q_op.delete(); q_addr.delete(); q_be.delete();
      for (int i = 0; i < 2; i++) begin
        q_op.push_back(0); q_addr.push_back(0); q_be.push_back('1);
      end
      exp_vld = 1'b0;
      last_ty = 0;
      b_k = 0;
    end else if (clk_en) begin
      if (q_op[0] == 2) begin
        for (int i = 0; i < NB; i++)
          if (!q_be[0][i]) ref_mem[q_addr[0]][i*BW +: BW] = dq_in[i*BW +: BW];
      end
      exp_vld = (q_op[0] == 1);
      if (exp_vld) exp_data = ref_mem[q_addr[0]];
      void'(q_op.pop_front()); void'(q_addr.pop_front()); void'(q_be.pop_front());
      if (adv) begin
        b_k = b_k + 1;
        ty = last_ty;
        a = (b_start & ~3) | (burst_ilv ? ((b_start ^ b_k) & 3) : ((b_start + b_k) % 4));
      end else begin
        b_start = int'(addr);
        b_k = 0;
        ty = (!cs0_n && cs1 && !cs2_n) ? (rd_wr_n ? 1 : 2) : 0;
        a = int'(addr);
      end
      last_ty = ty;
      q_op.push_back(ty); q_addr.push_back(a); q_be.push_back(be_n);
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      n_checks++;
      if (dq_oe !== (exp_vld && !oe_n)) begin
        n_errors++;
        $display("FAIL %s: dq_oe=%0b expected %0b at %0t", tag, dq_oe, exp_vld && !oe_n, $time);
      end
      if (exp_vld && !oe_n) begin
        n_checks++;
        if (dq_out !== exp_data) begin
          n_errors++;
          $display("FAIL %s: dq_out=%h expected %h at %0t", tag, dq_out, exp_data, $time);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  task automatic drive(input logic [2:0] cs, input logic rw, input logic av, input int ad,
                       input logic [NB-1:0] be, input logic ilv, input logic ce, input logic oe);
    logic [63:0] r;
    @(negedge clk);
    #1;
    r = {$urandom(), $urandom()};
    {cs2_n, cs1, cs0_n} = cs;
    rd_wr_n = rw; adv = av; addr = ad[AW-1:0]; be_n = be;
    burst_ilv = ilv; clk_en = ce; oe_n = oe; dq_in = r[W-1:0];
  endtask

  task automatic wr(input int ad, input logic [NB-1:0] be);
    drive(SEL, 1'b0, 1'b0, ad, be, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic rd(input int ad);
    drive(SEL, 1'b1, 1'b0, ad, '1, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic nop();
    drive(3'b101, 1'b1, 1'b0, 0, '1, 1'b0, 1'b1, 1'b0);
  endtask
  task automatic step(input logic ilv, input logic [NB-1:0] be);
    // garbage on addr/select/rw: must be ignored during a burst
    drive(3'b111, $urandom_range(0, 1), 1'b1, $urandom_range(0, DEPTH-1), be, ilv, 1'b1, 1'b0);
  endtask

  initial begin
    // R11: reset state
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_checks++;
      if (dq_oe !== 1'b0) begin
        n_errors++;
        $display("FAIL R11: dq_oe=%0b expected 0 during reset", dq_oe);
      end
    end
    #1 rst = 1'b0;
    nop(); nop();

    // R1 R2 R6: fill the array with linear write bursts
    tag = "R2";
    for (int g = 0; g < DEPTH / 4; g++) begin
      wr(g * 4, '0);
      for (int k = 0; k < 3; k++) step(1'b0, '0);
    end
    nop(); nop();

    // R3 R7: read bursts in both orders from unaligned starts
    tag = "R7";
    rd(6); for (int k = 0; k < 5; k++) step(1'b1, '1);
    rd(9); for (int k = 0; k < 5; k++) step(1'b0, '1);
    tag = "R3";
    for (int i = 0; i < 8; i++) rd(i * 3 % DEPTH);
    nop(); nop();

    // R4: strict alternation on a few words, read after write of same word
    tag = "R4";
    for (int i = 0; i < 16; i++) begin
      wr(i % 3, 4'($urandom_range(0, 15)));
      rd(i % 3);
    end
    nop(); nop();

    // R5: partial lane writes then read back
    tag = "R5";
    wr(12, 4'b1010); wr(13, 4'b0101); wr(14, 4'b1111); wr(15, 4'b0000);
    rd(12); rd(13); rd(14); rd(15);
    nop(); nop();

    // R6: burst write with changing lanes, burst after deselect
    tag = "R6";
    wr(20, '0); step(1'b1, 4'b1100); step(1'b1, 4'b0011); step(1'b1, '0);
    nop(); step(1'b0, '0); step(1'b0, '0);
    rd(20); step(1'b1, '1); step(1'b1, '1); step(1'b1, '1);
    nop(); nop();

    // R8: stalls between command, data and output
    tag = "R8";
    wr(5, '0);
    drive(SEL, 1'b1, 1'b0, 5, '1, 1'b0, 1'b0, 1'b0);
    drive(SEL, 1'b0, 1'b1, 7, '0, 1'b1, 1'b0, 1'b0);
    rd(5);
    drive(3'b101, 1'b0, 1'b0, 5, '0, 1'b0, 1'b0, 1'b0);
    rd(5); nop();
    drive(3'b101, 1'b1, 1'b0, 0, '1, 1'b0, 1'b0, 1'b0);
    nop(); nop();

    // R9: each select deasserted on its own
    tag = "R9";
    rd(1); drive(3'b011, 1'b0, 1'b0, 1, '0, 1'b0, 1'b1, 1'b0);
    rd(2); drive(3'b000, 1'b0, 1'b0, 2, '0, 1'b0, 1'b1, 1'b0);
    rd(3); drive(3'b110, 1'b0, 1'b0, 3, '0, 1'b0, 1'b1, 1'b0);
    rd(1); rd(2); rd(3); nop(); nop(); nop();

    // R10: output enable gating on reads and writes
    tag = "R10";
    drive(SEL, 1'b0, 1'b0, 8, '0, 1'b0, 1'b1, 1'b1);
    rd(8);
    drive(SEL, 1'b1, 1'b0, 8, '1, 1'b0, 1'b1, 1'b1);
    drive(SEL, 1'b1, 1'b0, 8, '1, 1'b0, 1'b1, 1'b1);
    rd(8); nop(); nop();

    // R11: reset discards a pending read
    tag = "R11";
    rd(4);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    nop(); nop(); nop();

    // R4: random traffic over all features
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      int c = $urandom_range(0, 9);
      drive(c == 9 ? 3'b111 : SEL, $urandom_range(0, 1), (c >= 7) && (c < 9),
            $urandom_range(0, DEPTH - 1), 4'($urandom_range(0, 15)),
            $urandom_range(0, 1), $urandom_range(0, 7) != 0, $urandom_range(0, 5) == 0);
    end
    nop(); nop(); nop();

    finish_run();
  end

endmodule